// File: doc/BRIEF.md
# Conversion Start and End-of-Conversion Sequencer

This block decides when a multichannel converter begins each conversion and drives the active-low end-of-conversion flag (`eoc_n`). A two-bit clock-mode field picks the start source and the flag behaviour. In the two pin-driven modes, a qualified low pulse on the asynchronous `cnvst_n` input either runs the whole set of selected channels (scan) or exactly one channel (single step). In the two command-driven modes, a one-cycle `cmd_req` strobe from the serial front end either runs the whole set (scan) or one externally timed conversion, which never raises an end-of-conversion indication.

Every conversion is announced by a one-cycle `start_pulse` together with the channel number on `start_chan`. A fixed-latency converter model inside the block returns a completion pulse, and the next conversion or the end flag follows from it. A request that arrives while a sequence is still running is dropped and recorded in a sticky flag.

Top module: `cvs_sequencer`

## Requirements
- R1: In mode 2'b00, a `cnvst_n` low pulse that lasts at least SCAN_MIN synchronized cycles starts one conversion for every set bit of `chan_mask`, in ascending channel order.
- R2: A `cnvst_n` low pulse that is shorter than the minimum for the current pin mode (SCAN_MIN in mode 2'b00, SINGLE_MIN in mode 2'b01) starts no conversion.
- R3: In mode 2'b01, each `cnvst_n` low pulse of at least SINGLE_MIN cycles starts exactly one conversion. The channel is the first set mask bit at or above a pointer that starts at 0 after reset, wraps at NCH, and moves to one past the channel just converted.
- R4: In mode 2'b10, `cmd_req` starts a scan of all selected channels in ascending order. In this mode `cnvst_n` starts nothing and does not change `eoc_n`.
- R5: In mode 2'b11, `cmd_req` starts exactly one conversion, chosen with the same round-robin pointer as R3, and `eoc_n` stays high.
- R6: In scan modes, `eoc_n` stays high until the last conversion of the sequence completes and goes low LATENCY+1 cycles after the last `start_pulse`.
- R7: In mode 2'b01, `eoc_n` goes low after each single conversion completes.
- R8: A falling edge on `cs_n`, or a synchronized falling edge on `cnvst_n` in modes 2'b00 and 2'b01, drives `eoc_n` high on the next cycle. This clearing takes priority over a sequence ending in the same cycle.
- R9: A request that arrives while a sequence is running is ignored, and `ovr_flag` is set and stays set until reset.
- R10: The converter completes LATENCY cycles after each `start_pulse`. Within a scan, consecutive start pulses are exactly LATENCY+2 cycles apart, and no start is issued while a conversion is in flight.
- R11: While reset is held, and right after it, `eoc_n` is 1, `ovr_flag` is 0 and `start_pulse` is 0.
- R12: `cmd_req` has no effect in modes 2'b00 and 2'b01. A request made with an all-zero `chan_mask` starts nothing and does not set `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Clock mode: 00 pin scan, 01 pin single, 10 command scan, 11 external clock |
| chan_mask | input | NCH | Channels selected for conversion, bit i = channel i |
| cmd_req | input | 1 | One-cycle conversion command from the serial front end |
| cs_n | input | 1 | Chip select, active low, already in the `clk` domain |
| cnvst_n | input | 1 | Asynchronous active-low conversion start pin |
| start_pulse | output | 1 | One-cycle conversion start |
| start_chan | output | $clog2(NCH) | Channel of the current start |
| eoc_n | output | 1 | Active-low end-of-conversion flag |
| ovr_flag | output | 1 | Sticky flag: a request was dropped while busy |

## Verification
On every cycle, the bound checker enforces the converter latency, the rule that no start overlaps a conversion in flight, the forced-high flag in external mode, flag clearing after a chip-select fall, the link between every fall of `eoc_n` and a completion one cycle earlier, the sticky overrun flag, and the reset values. Only the bench scenarios can show the start order across a scan, the round-robin pointer across several pin pulses, the rejection of short pulses, and the dropping of commands or pin pulses in the modes that ignore them, because each of these depends on a history of stimulus and a reference model.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

   typedef enum logic [1:0] {
      CK_PIN_SCAN   = 2'b00,
      CK_PIN_SINGLE = 2'b01,
      CK_CMD_SCAN   = 2'b10,
      CK_EXT        = 2'b11
   } clk_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'b00,
      SQ_ISSUE = 2'b01,
      SQ_WAIT  = 2'b10
   } seq_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cvs_pin_qual.sv
// Synchronizes the start pin, reports its falling edge and qualifies
// the low-pulse width at the rising edge against two minimums.
module cvs_pin_qual
   import cvs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SCAN_MIN    = 10,
   parameter int SINGLE_MIN  = 350
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall_o,
   output logic ok_scan_o,
   output logic ok_single_o
);
   localparam int MAXW = max_of(SCAN_MIN, SINGLE_MIN);
   localparam int CW   = $clog2(MAXW + 1);

   logic pin_s;
   logic pin_d;
   logic [CW-1:0] low_cnt;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg;
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[0] <= 1'b1;
                  else        stg[0] <= pin_n;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[s] <= 1'b1;
                  else        stg[s] <= stg[s-1];
               end
            end
         end
         assign pin_s = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d   <= 1'b1;
         low_cnt <= '0;
      end else begin
         pin_d <= pin_s;
         if (pin_s)
            low_cnt <= '0;
         else if (low_cnt != CW'(MAXW))
            low_cnt <= low_cnt + 1'b1;
      end
   end

   assign rise        = ~pin_d & pin_s;
   assign fall_o      = pin_d & ~pin_s;
   assign ok_scan_o   = rise && (low_cnt >= CW'(SCAN_MIN));
   assign ok_single_o = rise && (low_cnt >= CW'(SINGLE_MIN));

endmodule

// File: rtl/cvs_chan_pick.sv
// Finds the first set bit of a vector at or above a base index, with wrap.
module cvs_chan_pick #(
   parameter int NCH = 12,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [NCH-1:0] vec,
   input  logic [CHW-1:0] base,
   output logic           found,
   output logic [CHW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < NCH; k++) begin
         int j;
         j = int'(base) + k;
         if (j >= NCH) j = j - NCH;
         if (!found && vec[j]) begin
            found = 1'b1;
            idx   = CHW'(j);
         end
      end
   end
endmodule

// File: rtl/cvs_conv_model.sv
// Fixed-latency stand-in for the analog converter.
module cvs_conv_model #(
   parameter int LATENCY = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done,
   output logic busy
);
   localparam int LW = $clog2(LATENCY + 1);
   logic [LW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start)          cnt <= LW'(LATENCY);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign done = (cnt == LW'(1));
   assign busy = (cnt != '0);
endmodule

// File: rtl/cvs_sequencer.sv
module cvs_sequencer
   import cvs_pkg::*;
#(
   parameter int NCH         = 12,
   parameter int LATENCY     = 20,
   parameter int SYNC_STAGES = 2,
   parameter int SCAN_MIN    = 10,
   parameter int SINGLE_MIN  = 350,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     mode,
   input  logic [NCH-1:0] chan_mask,
   input  logic           cmd_req,
   input  logic           cs_n,
   input  logic           cnvst_n,
   output logic           start_pulse,
   output logic [CHW-1:0] start_chan,
   output logic           eoc_n,
   output logic           ovr_flag
);
   generate
      if (NCH < 2)         begin : g_bad_nch  $error("NCH must be at least 2");        end
      if (LATENCY < 2)     begin : g_bad_lat  $error("LATENCY must be at least 2");    end
      if (SCAN_MIN < 1)    begin : g_bad_scan $error("SCAN_MIN must be positive");     end
      if (SINGLE_MIN < 1)  begin : g_bad_sing $error("SINGLE_MIN must be positive");   end
      if (SYNC_STAGES < 0) begin : g_bad_sync $error("SYNC_STAGES cannot be negative"); end
   endgenerate

   clk_mode_e  md;
   seq_state_e state;
   logic       pin_fall, pin_ok_scan, pin_ok_single;
   logic       cs_d, cs_fall;
   logic       req_evt, single_req, busy, seq_end, clr_evt;
   logic [NCH-1:0] rem;
   logic       single_q;
   logic [CHW-1:0] ptr, pick_base, pick_idx;
   logic       pick_found;
   logic       conv_done, model_busy;

   assign md = clk_mode_e'(mode);

   cvs_pin_qual #(
      .SYNC_STAGES(SYNC_STAGES),
      .SCAN_MIN   (SCAN_MIN),
      .SINGLE_MIN (SINGLE_MIN)
   ) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_n      (cnvst_n),
      .fall_o     (pin_fall),
      .ok_scan_o  (pin_ok_scan),
      .ok_single_o(pin_ok_single)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_d <= 1'b1;
      else        cs_d <= cs_n;
   end
   assign cs_fall = cs_d & ~cs_n;

   // start source by mode
   always_comb begin
      req_evt    = 1'b0;
      single_req = 1'b0;
      unique case (md)
         CK_PIN_SCAN:   req_evt = pin_ok_scan;
         CK_PIN_SINGLE: begin req_evt = pin_ok_single; single_req = 1'b1; end
         CK_CMD_SCAN:   req_evt = cmd_req;
         CK_EXT:        begin req_evt = cmd_req; single_req = 1'b1; end
         default:       req_evt = 1'b0;
      endcase
   end

   assign busy      = (state != SQ_IDLE);
   assign pick_base = single_q ? ptr : '0;
   assign seq_end   = (state == SQ_WAIT) && conv_done && (rem == '0);
   assign clr_evt   = cs_fall || (pin_fall && !mode[1]);

   cvs_chan_pick #(.NCH(NCH)) u_pick (
      .vec  (rem),
      .base (pick_base),
      .found(pick_found),
      .idx  (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SQ_IDLE;
         rem         <= '0;
         single_q    <= 1'b0;
         ptr         <= '0;
         start_pulse <= 1'b0;
         start_chan  <= '0;
      end else begin
         start_pulse <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (req_evt && (chan_mask != '0)) begin
                  rem      <= chan_mask;
                  single_q <= single_req;
                  state    <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               if (pick_found) begin
                  start_pulse <= 1'b1;
                  start_chan  <= pick_idx;
                  if (single_q) begin
                     rem <= '0;
                     ptr <= (pick_idx == CHW'(NCH - 1)) ? '0 : pick_idx + 1'b1;
                  end else begin
                     rem[pick_idx] <= 1'b0;
                  end
                  state <= SQ_WAIT;
               end else begin
                  state <= SQ_IDLE;
               end
            end
            SQ_WAIT: begin
               if (conv_done)
                  state <= (rem == '0) ? SQ_IDLE : SQ_ISSUE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovr_flag <= 1'b0;
      else if (req_evt && busy)  ovr_flag <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              eoc_n <= 1'b1;
      else if (md == CK_EXT)   eoc_n <= 1'b1;
      else if (clr_evt)        eoc_n <= 1'b1;
      else if (seq_end)        eoc_n <= 1'b0;
   end

   cvs_conv_model #(.LATENCY(LATENCY)) u_conv (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start_pulse),
      .done (conv_done),
      .busy (model_busy)
   );

endmodule

// File: rtl/cvs_sequencer_chk.sv
module cvs_sequencer_chk #(
   parameter int NCH     = 12,
   parameter int LATENCY = 20,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [1:0]     mode,
   input logic           cs_n,
   input logic           start_pulse,
   input logic [CHW-1:0] start_chan,
   input logic           eoc_n,
   input logic           ovr_flag,
   input logic           conv_done,
   input logic           model_busy
);
   logic [15:0] since_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    since_start <= '0;
      else if (start_pulse)          since_start <= 16'd1;
      else if (since_start != '1)    since_start <= since_start + 16'd1;
   end

   assert_reset_vals_R11: assert property (@(posedge clk)
      !rst_n |=> (eoc_n && !ovr_flag && !start_pulse));

   assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (int'(start_chan) < NCH));

   assert_ext_eoc_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && $past(mode) == 2'b11) |-> eoc_n);

   assert_eoc_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc_n) |-> $past(conv_done));

   assert_cs_clears_eoc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> eoc_n);

   assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);

   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> !model_busy);

   assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> (since_start == 16'(LATENCY)));

endmodule

bind cvs_sequencer cvs_sequencer_chk #(.NCH(NCH), .LATENCY(LATENCY)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .cs_n       (cs_n),
   .start_pulse(start_pulse),
   .start_chan (start_chan),
   .eoc_n      (eoc_n),
   .ovr_flag   (ovr_flag),
   .conv_done  (conv_done),
   .model_busy (model_busy)
);

// File: tb/tb_cvs_sequencer.sv
module tb_cvs_sequencer;
   localparam int NCH   = 12;
   localparam int CHW   = 4;
   localparam int LAT   = 20;
   localparam int SYNC  = 2;
   localparam int SCANW = 10;
   localparam int SINGW = 350;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [NCH-1:0] chan_mask = '0;
   logic cmd_req = 1'b0;
   logic cs_n = 1'b1;
   logic cnvst_n = 1'b1;
   logic start_pulse;
   logic [CHW-1:0] start_chan;
   logic eoc_n;
   logic ovr_flag;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   int cyc = 0;

   int nlog;
   int chlog [64];
   bit eoclog [64];
   int last_start, prev_start, min_gap, max_gap, eoc_fall_cyc;
   bit prev_eoc = 1'b1;
   int exp_ch [64];
   int exp_n;
   int ptr_m;

   cvs_sequencer #(
      .NCH(NCH), .LATENCY(LAT), .SYNC_STAGES(SYNC),
      .SCAN_MIN(SCANW), .SINGLE_MIN(SINGW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .chan_mask(chan_mask),
      .cmd_req(cmd_req), .cs_n(cs_n), .cnvst_n(cnvst_n),
      .start_pulse(start_pulse), .start_chan(start_chan),
      .eoc_n(eoc_n), .ovr_flag(ovr_flag)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (start_pulse) begin
         if (nlog < 64) begin
            chlog[nlog]  = int'(start_chan);
            eoclog[nlog] = eoc_n;
         end
         if (nlog > 0) begin
            if (cyc - prev_start < min_gap) min_gap = cyc - prev_start;
            if (cyc - prev_start > max_gap) max_gap = cyc - prev_start;
         end
         prev_start = cyc;
         last_start = cyc;
         nlog++;
      end
      if (prev_eoc && !eoc_n) eoc_fall_cyc = cyc;
      prev_eoc = eoc_n;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_log();
      nlog = 0;
      min_gap = 1 << 30;
      max_gap = 0;
      eoc_fall_cyc = -1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cmd_req = 1'b0; cs_n = 1'b1; cnvst_n = 1'b1;
      tick(3);
      rst_n = 1'b1;
      ptr_m = 0;
      tick(2);
   endtask

   task automatic pin_pulse(input int w);
      cnvst_n = 1'b0;
      tick(w);
      cnvst_n = 1'b1;
      tick(SYNC + 3);
   endtask

   task automatic command();
      cs_n = 1'b0;
      tick(1);
      cmd_req = 1'b1;
      tick(1);
      cmd_req = 1'b0;
      cs_n = 1'b1;
      tick(1);
   endtask

   // reference: next set bit at or above ptr, with wrap
   function automatic int next_single(input logic [NCH-1:0] m, input int p);
      for (int k = 0; k < NCH; k++) begin
         int j = (p + k) % NCH;
         if (m[j]) return j;
      end
      return -1;
   endfunction

   task automatic build_exp(input int md, input logic [NCH-1:0] m, input int pulses);
      exp_n = 0;
      if (m == '0) return;
      if (md == 0 || md == 2) begin
         for (int i = 0; i < NCH; i++) if (m[i]) begin exp_ch[exp_n] = i; exp_n++; end
      end else begin
         for (int p = 0; p < pulses; p++) begin
            int c = next_single(m, ptr_m);
            exp_ch[exp_n] = c; exp_n++;
            ptr_m = (c + 1) % NCH;
         end
      end
   endtask

   task automatic run_trial(input int md, input logic [NCH-1:0] m, input int pulses);
      int bad = 0;
      int eocbad = 0;
      int np = (md == 1 || md == 3) ? pulses : 1;
      mode = md[1:0];
      chan_mask = m;
      tick(3);
      clear_log();
      build_exp(md, m, np);
      for (int p = 0; p < np; p++) begin
         case (md)
            0: pin_pulse(SCANW + 2);
            1: pin_pulse(SINGW + 2);
            default: command();
         endcase
         tick(LAT + 10);
         if (md == 1 && m != '0) check("R7 eoc_n low after single conversion", eoc_n, 0);
      end
      tick(NCH * (LAT + 3) + 20);
      check((md == 0) ? "R1 start count" : (md == 1) ? "R3 start count" :
            (md == 2) ? "R4 start count" : "R5 start count", nlog, exp_n);
      for (int i = 0; i < exp_n && i < nlog; i++) if (chlog[i] != exp_ch[i]) bad++;
      check((md == 0) ? "R1 channel order" : (md == 1) ? "R3 round-robin channel" :
            (md == 2) ? "R4 channel order" : "R5 round-robin channel", bad, 0);
      for (int i = 0; i < nlog && i < 64; i++) if (!eoclog[i]) eocbad++;
      check("R6 eoc_n high while conversions run", eocbad, 0);
      if (md == 3 || m == '0) check("R5 eoc_n final level", eoc_n, 1);
      else check("R6 eoc_n low at end", eoc_n, 0);
      if ((md == 0 || md == 2) && exp_n > 0) begin
         check("R6 eoc fall after last start", eoc_fall_cyc - last_start, LAT + 1);
         if (exp_n > 1) begin
            check("R10 min start spacing", min_gap, LAT + 2);
            check("R10 max start spacing", max_gap, LAT + 2);
         end
      end
      check("R9 no overrun without overlap", ovr_flag, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired: actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4021));
      clear_log();
      tick(2);
      check("R11 eoc_n in reset", eoc_n, 1);
      check("R11 ovr_flag in reset", ovr_flag, 0);
      check("R11 start_pulse in reset", start_pulse, 0);
      do_reset();
      check("R11 eoc_n after reset", eoc_n, 1);

      // directed scans and steps
      run_trial(0, 12'hFFF, 1);
      run_trial(0, 12'h801, 1);
      run_trial(2, 12'h0A5, 1);
      run_trial(1, 12'h890, 3);
      run_trial(3, 12'h003, 3);

      // R2: short pulses
      mode = 2'b00; chan_mask = 12'h00F; tick(3); clear_log();
      pin_pulse(SCANW - 3); tick(LAT * 2);
      check("R2 short pulse in mode 00", nlog, 0);
      mode = 2'b01; tick(3); clear_log();
      pin_pulse(SCANW + 20); tick(LAT * 2);
      check("R2 short pulse in mode 01", nlog, 0);

      // R4: pin ignored in mode 10, eoc unchanged
      run_trial(2, 12'h00C, 1);
      clear_log();
      pin_pulse(SCANW + 2); tick(LAT * 2);
      check("R4 pin starts nothing in mode 10", nlog, 0);
      check("R4 pin leaves eoc_n low in mode 10", eoc_n, 0);

      // R8: chip select fall clears eoc_n
      cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(1);
      check("R8 cs_n fall clears eoc_n", eoc_n, 1);

      // R8: pin fall clears eoc_n in mode 01
      run_trial(1, 12'h100, 1);
      cnvst_n = 1'b0; tick(SYNC + 3);
      check("R8 cnvst_n fall clears eoc_n", eoc_n, 1);
      cnvst_n = 1'b1; tick(SYNC + 3);

      // R12: command ignored in pin modes, empty mask dropped
      mode = 2'b00; chan_mask = 12'h0FF; tick(3); clear_log();
      command(); tick(LAT * 2);
      check("R12 command ignored in mode 00", nlog, 0);
      mode = 2'b01; tick(3); clear_log();
      command(); tick(LAT * 2);
      check("R12 command ignored in mode 01", nlog, 0);
      run_trial(2, 12'h000, 1);
      check("R12 empty mask leaves ovr_flag clear", ovr_flag, 0);

      // R9: request while busy
      do_reset();
      mode = 2'b10; chan_mask = 12'hFFF; tick(3); clear_log();
      command(); tick(5); command();
      tick(NCH * (LAT + 3) + 20);
      check("R9 busy request sets ovr_flag", ovr_flag, 1);
      check("R9 busy request adds no starts", nlog, NCH);
      tick(20);
      check("R9 ovr_flag sticky", ovr_flag, 1);
      do_reset();
      check("R11 reset clears ovr_flag", ovr_flag, 0);

      // random trials
      for (int t = 0; t < 40; t++) begin
         int md = int'($urandom_range(0, 3));
         logic [NCH-1:0] m = NCH'($urandom);
         if ($urandom_range(0, 3) == 0) m = m & NCH'($urandom);
         run_trial(md, m, int'($urandom_range(1, 3)));
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule